// File: doc/BRIEF.md
# Three-Wire Serial Register Bus Slave

This block is the device side of a three-wire serial bus made of a bus clock, one shared data line and an active-low select. While select is low, each rising edge of the bus clock moves one bit, most significant bit first. Every transfer opens with a 9-bit command word. The command carries a 3-bit device address, a direction flag and a 5-bit register index. A 16-bit value phase follows the command. After the value phase the slave expects a new command, so the master may hold select low across several transfers.

The three bus inputs pass through synchronizer flops into the system clock domain, and the bus clock edges are detected there. A command is accepted only when its device address equals the `MY_DEV` parameter. Up to eight slaves can then share the bus. On an accepted write, the slave gives a one-cycle write strobe with the register index and the assembled 16-bit value. On an accepted read, it gives a one-cycle read request as soon as the command is complete. It captures the register file's answer in the next system clock, turns on its data output enable, and presents the value one bit per bus clock edge.

Top module: `tws_slave`

## Requirements
- R1: After reset, `bus_doe`, `reg_wr` and `reg_rd` are low.
- R2: The command word is sent MSB first. Bits [8:6] are the device address, bit [5] is the direction (1 = read, 0 = write) and bits [4:0] are the register index. After the command, `reg_addr` shows the index and holds it through the value phase.
- R3: On a write addressed to `MY_DEV`, the 16 value bits are sampled MSB first. `reg_wr` is high for exactly one system clock, SYNC_STAGES+1 cycles after the 16th value-phase bus clock rising edge is applied, with `reg_wdata` carrying the value.
- R4: On a read addressed to `MY_DEV`, `reg_rd` is high for exactly one system clock, SYNC_STAGES+1 cycles after the 9th bus clock rising edge. Value bit 15 is on `bus_dout` before the first value-phase rising edge. Each value-phase rising edge advances `bus_dout` to the next lower bit.
- R5: `bus_doe` is high only during the value phase of a read addressed to `MY_DEV`. It is low during the command phase and during writes, and it is released after the 16th value-phase edge.
- R6: A transfer whose device address differs from `MY_DEV` produces no strobe and no read request, keeps `bus_doe` low, and leaves the register file unchanged.
- R7: Raising select at any point aborts the transfer. No strobe is issued, `bus_doe` drops, and the next transfer starts with a fresh command phase.
- R8: Bus clock edges while select is high are ignored. They neither advance the bit count nor cause any strobe.
- R9: With select held low, a new command phase begins directly after a value phase, and back-to-back transfers work.
- R10: `reg_wr` and `reg_rd` are never high in the same cycle, and each lasts a single cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_clk | input | 1 | Serial bus clock from the master |
| bus_sel_n | input | 1 | Active-low transfer select |
| bus_din | input | 1 | Serial data line, input side |
| bus_dout | output | 1 | Serial data line, output side |
| bus_doe | output | 1 | Output enable for the data line driver |
| reg_addr | output | 5 | Register index of the current command |
| reg_rd | output | 1 | One-cycle read request to the register file |
| reg_rdata | input | 16 | Register contents, valid in the cycle `reg_rd` is high |
| reg_wr | output | 1 | One-cycle write strobe |
| reg_wdata | output | 16 | Value to write, valid with `reg_wr` |

## Verification
The assertions assume a bus clock that is slow compared with `clk`. Each bus half period must last longer than SYNC_STAGES+3 system clocks, so that a read capture completes before the next edge. The data line and select must change only while the bus clock is low. The register file is assumed to answer combinationally in the cycle `reg_rd` is high. The stimulus keeps a half period of eight system clocks and changes data and select on the falling bus clock. The bench's register model reads `reg_rdata` straight from `reg_addr`.

// File: rtl/tws_pkg.sv
package tws_pkg;
  localparam int DEV_W = 3;
  localparam int IDX_W = 5;
  localparam int CMD_W = DEV_W + 1 + IDX_W;
  localparam int VAL_W = 16;
  localparam int CNT_W = $clog2(VAL_W);

  typedef enum logic { PH_CMD = 1'b0, PH_VAL = 1'b1 } phase_t;

  typedef struct packed {
    logic [DEV_W-1:0] dev;
    logic             rd;
    logic [IDX_W-1:0] idx;
  } cmd_t;

  // split a received command word into its fields
  function automatic cmd_t cmd_split(input logic [CMD_W-1:0] w);
    cmd_t c;
    c.dev = w[CMD_W-1 -: DEV_W];
    c.rd  = w[IDX_W];
    c.idx = w[IDX_W-1:0];
    return c;
  endfunction

  // true when the current bit is the final one of its phase
  function automatic logic phase_last(input phase_t ph, input logic [CNT_W-1:0] cnt);
    return (ph == PH_CMD) ? (cnt == CNT_W'(CMD_W-1)) : (cnt == CNT_W'(VAL_W-1));
  endfunction

  function automatic logic dev_hit(input logic [DEV_W-1:0] dev, input logic [DEV_W-1:0] mine);
    return dev == mine;
  endfunction
endpackage

// File: rtl/tws_sync.sv
module tws_sync #(
  parameter int               WIDTH   = 1,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      logic [WIDTH-1:0] r;
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) r <= RST_VAL;
          else        r <= d;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) r <= RST_VAL;
          else        r <= g_stage[s-1].r;
      end
    end
  endgenerate

  assign q = g_stage[STAGES-1].r;
endmodule

// File: rtl/tws_front.sv
module tws_front #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_clk,
  input  logic bus_din,
  input  logic bus_sel_n,
  output logic rise,
  output logic din_s,
  output logic idle
);
  logic [2:0] s;
  logic       clk_d;

  // bit 2 select (idle high), bit 1 bus clock, bit 0 data
  tws_sync #(.WIDTH(3), .STAGES(STAGES), .RST_VAL(3'b100)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({bus_sel_n, bus_clk, bus_din}),
    .q    (s)
  );

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) clk_d <= 1'b0;
    else        clk_d <= s[1];

  assign idle  = s[2];
  assign din_s = s[0];
  assign rise  = s[1] & ~clk_d & ~s[2];
endmodule

// File: rtl/tws_seq.sv
module tws_seq
  import tws_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rise,
  input  logic             idle,
  output phase_t           phase,
  output logic [CNT_W-1:0] cnt,
  output logic             cmd_done,
  output logic             val_done
);
  logic last;

  assign last     = phase_last(phase, cnt);
  assign cmd_done = rise & last & (phase == PH_CMD);
  assign val_done = rise & last & (phase == PH_VAL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_CMD;
      cnt   <= '0;
    end else if (idle) begin
      phase <= PH_CMD;
      cnt   <= '0;
    end else if (rise) begin
      if (last) begin
        cnt   <= '0;
        phase <= (phase == PH_CMD) ? PH_VAL : PH_CMD;
      end else begin
        cnt <= cnt + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/tws_shift.sv
module tws_shift
  import tws_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rise,
  input  logic             din,
  input  logic             load,
  input  logic             shift_out,
  input  logic [VAL_W-1:0] load_val,
  output logic [VAL_W-1:0] in_word,
  output logic             dout
);
  logic [VAL_W-2:0] ish;
  logic [VAL_W-1:0] osh;

  // word as it stands including the bit sampled on this edge
  assign in_word = {ish, din};
  assign dout    = osh[VAL_W-1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)    ish <= '0;
    else if (rise) ish <= in_word[VAL_W-2:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)         osh <= '0;
    else if (load)      osh <= load_val;
    else if (shift_out) osh <= {osh[VAL_W-2:0], 1'b0};
endmodule

// File: rtl/tws_slave.sv
module tws_slave
  import tws_pkg::*;
#(
  parameter logic [DEV_W-1:0] MY_DEV      = 3'd5,
  parameter int               SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_clk,
  input  logic             bus_sel_n,
  input  logic             bus_din,
  output logic             bus_dout,
  output logic             bus_doe,
  output logic [IDX_W-1:0] reg_addr,
  output logic             reg_rd,
  input  logic [VAL_W-1:0] reg_rdata,
  output logic             reg_wr,
  output logic [VAL_W-1:0] reg_wdata
);
  logic             rise, idle, din_s;
  phase_t           phase;
  logic [CNT_W-1:0] cnt;
  logic             cmd_done, val_done;
  logic [VAL_W-1:0] in_word;
  cmd_t             cmd_new, cmd_q;
  logic             hit_q, rd_q, wr_q, wr_take, shift_en;
  logic [VAL_W-1:0] wdata_q;
  logic [DEV_W-1:0] cur_dev;
  logic             cur_rd;

  tws_front #(.STAGES(SYNC_STAGES)) u_front (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_clk  (bus_clk),
    .bus_din  (bus_din),
    .bus_sel_n(bus_sel_n),
    .rise     (rise),
    .din_s    (din_s),
    .idle     (idle)
  );

  tws_seq u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .rise    (rise),
    .idle    (idle),
    .phase   (phase),
    .cnt     (cnt),
    .cmd_done(cmd_done),
    .val_done(val_done)
  );

  assign cmd_new  = cmd_split(in_word[CMD_W-1:0]);
  assign bus_doe  = (phase == PH_VAL) & hit_q & cmd_q.rd;
  assign shift_en = rise & bus_doe;
  assign wr_take  = val_done & hit_q & ~cmd_q.rd;

  tws_shift u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .rise     (rise),
    .din      (din_s),
    .load     (rd_q),
    .shift_out(shift_en),
    .load_val (reg_rdata),
    .in_word  (in_word),
    .dout     (bus_dout)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q   <= '0;
      hit_q   <= 1'b0;
      rd_q    <= 1'b0;
      wr_q    <= 1'b0;
      wdata_q <= '0;
    end else begin
      rd_q <= cmd_done & dev_hit(cmd_new.dev, MY_DEV) & cmd_new.rd;
      wr_q <= wr_take;
      if (cmd_done) begin
        cmd_q <= cmd_new;
        hit_q <= dev_hit(cmd_new.dev, MY_DEV);
      end
      if (wr_take) wdata_q <= in_word;
    end
  end

  assign reg_addr  = cmd_q.idx;
  assign reg_rd    = rd_q;
  assign reg_wr    = wr_q;
  assign reg_wdata = wdata_q;
  assign cur_dev   = cmd_q.dev;
  assign cur_rd    = cmd_q.rd;
endmodule

// File: rtl/tws_slave_chk.sv
module tws_slave_chk
  import tws_pkg::*;
#(
  parameter logic [DEV_W-1:0] MY_DEV = 3'd5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rise,
  input logic             idle,
  input phase_t           phase,
  input logic [CNT_W-1:0] cnt,
  input logic             cmd_done,
  input logic             val_done,
  input logic [DEV_W-1:0] cur_dev,
  input logic             cur_rd,
  input logic             bus_doe,
  input logic             reg_rd,
  input logic             reg_wr,
  input logic [IDX_W-1:0] reg_addr
);
  // R2: index held during the value phase
  a_r2_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_VAL && $past(phase) == PH_VAL) |-> $stable(reg_addr));

  // R3: write strobe follows the final value bit of a write
  a_r3_wr_after_val: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |-> ($past(val_done) && !cur_rd));

  // R4: read request follows command completion
  a_r4_rd_after_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |-> ($past(cmd_done) && phase == PH_VAL));

  // R5 / R6: driver on only for a matched read in the value phase
  a_r5_doe_window: assert property (@(posedge clk) disable iff (!rst_n)
    bus_doe |-> (phase == PH_VAL && cur_rd && cur_dev == MY_DEV));

  // R7: select high returns to a clean command phase
  a_r7_abort: assert property (@(posedge clk) disable iff (!rst_n)
    idle |=> (cnt == '0 && phase == PH_CMD && !bus_doe));

  // R8: no bus edge means no progress
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!rise && !idle) |=> ($stable(cnt) && $stable(phase)));

  // R10: single-cycle, mutually exclusive strobes
  a_r10_wr_single: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> !reg_wr);
  a_r10_rd_single: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |=> !reg_rd);
  a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_rd));
endmodule

bind tws_slave tws_slave_chk #(.MY_DEV(MY_DEV)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .rise    (rise),
  .idle    (idle),
  .phase   (phase),
  .cnt     (cnt),
  .cmd_done(cmd_done),
  .val_done(val_done),
  .cur_dev (cur_dev),
  .cur_rd  (cur_rd),
  .bus_doe (bus_doe),
  .reg_rd  (reg_rd),
  .reg_wr  (reg_wr),
  .reg_addr(reg_addr)
);

// File: tb/tws_slave_tb.sv
module tws_slave_tb;
  localparam logic [2:0] MY   = 3'd5;
  localparam int         HALF = 8;
  localparam int         LAT  = 3;   // SYNC_STAGES + 1
  localparam int         NV   = 9;
  // {dev, read, index, value}
  localparam logic [24:0] VEC [NV] = '{
    {3'd5, 1'b0, 5'd3,  16'hA5C3},
    {3'd5, 1'b0, 5'd31, 16'h8001},
    {3'd5, 1'b1, 5'd3,  16'h0000},
    {3'd2, 1'b0, 5'd3,  16'hFFFF},
    {3'd5, 1'b1, 5'd3,  16'h0000},
    {3'd5, 1'b0, 5'd0,  16'h7E18},
    {3'd5, 1'b1, 5'd31, 16'h0000},
    {3'd7, 1'b1, 5'd0,  16'h0000},
    {3'd5, 1'b1, 5'd0,  16'h0000}
  };

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n, bus_clk, bus_sel_n, bus_din;
  logic        bus_dout, bus_doe, reg_rd, reg_wr;
  logic [4:0]  reg_addr;
  logic [15:0] reg_rdata, reg_wdata;
  logic [15:0] rf [32];
  logic [15:0] exp_mem [32];

  tws_slave #(.MY_DEV(MY), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_clk(bus_clk), .bus_sel_n(bus_sel_n),
    .bus_din(bus_din), .bus_dout(bus_dout), .bus_doe(bus_doe),
    .reg_addr(reg_addr), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata)
  );

  // attached register file
  assign reg_rdata = rf[reg_addr];
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 32; i++) rf[i] <= 16'h0;
    end else if (reg_wr) begin
      rf[reg_addr] <= reg_wdata;
    end
  end

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int wr_cnt = 0, rd_cnt = 0, last_wr_cyc = 0, last_rd_cyc = 0;
  logic [15:0] last_wr_data;
  logic [4:0]  last_wr_addr;
  always @(negedge clk) begin
    if (reg_wr) begin
      wr_cnt <= wr_cnt + 1; last_wr_cyc <= cyc;
      last_wr_data <= reg_wdata; last_wr_addr <= reg_addr;
    end
    if (reg_rd) begin
      rd_cnt <= rd_cnt + 1; last_rd_cyc <= cyc;
    end
  end

  int checks = 0, errors = 0;
  int rise_cyc = 0, cmd_rise = 0;
  logic done = 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_bit(input logic b, output logic smp, output logic oe);
    bus_din = b;
    repeat (HALF) @(negedge clk);
    smp = bus_dout;
    oe  = bus_doe;
    bus_clk  = 1'b1;
    rise_cyc = cyc;
    repeat (HALF) @(negedge clk);
    bus_clk = 1'b0;
  endtask

  task automatic xfer(input logic [2:0] dev, input logic rd, input logic [4:0] idx,
                      input logic [15:0] wd, input int nval, input logic keep,
                      output logic [15:0] rv, output logic oe_all, output logic oe_any,
                      output logic cmd_oe);
    logic [8:0] c;
    logic s, o;
    c = {dev, rd, idx};
    rv = '0; oe_all = 1'b1; oe_any = 1'b0; cmd_oe = 1'b0;
    bus_sel_n = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 8; i >= 0; i--) begin
      bus_bit(c[i], s, o);
      cmd_oe |= o;
    end
    cmd_rise = rise_cyc;
    for (int i = 15; i >= 16 - nval; i--) begin
      bus_bit(wd[i], s, o);
      rv[i] = s; oe_all &= o; oe_any |= o;
    end
    repeat (HALF) @(negedge clk);
    if (!keep) begin
      bus_sel_n = 1'b1;
      repeat (HALF) @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog: actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [2:0]  dev;
    logic        rd, hit, oe_all, oe_any, cmd_oe;
    logic [4:0]  idx;
    logic [15:0] wd, rv;
    int          w0, r0;

    for (int i = 0; i < 32; i++) exp_mem[i] = 16'h0;
    rst_n = 1'b0; bus_clk = 1'b0; bus_sel_n = 1'b1; bus_din = 1'b0;
    repeat (5) @(negedge clk);
    chk("R1 doe after reset", bus_doe, 0);
    chk("R1 wr after reset", reg_wr, 0);
    chk("R1 rd after reset", reg_rd, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      {dev, rd, idx, wd} = VEC[v];
      hit = (dev == MY);
      w0 = wr_cnt; r0 = rd_cnt;
      xfer(dev, rd, idx, wd, 16, 1'b0, rv, oe_all, oe_any, cmd_oe);
      if (!rd) begin
        chk("R3/R6 write strobe count", wr_cnt - w0, hit ? 1 : 0);
        if (hit) begin
          chk("R3 write value", last_wr_data, wd);
          chk("R2 write index", last_wr_addr, idx);
          chk("R3 strobe latency", last_wr_cyc - rise_cyc, LAT);
          exp_mem[idx] = wd;
        end
      end else begin
        chk("R4/R6 read request count", rd_cnt - r0, hit ? 1 : 0);
        if (hit) begin
          chk("R4 read value", rv, exp_mem[idx]);
          chk("R5 doe through value phase", oe_all, 1);
          chk("R4 request latency", last_rd_cyc - cmd_rise, LAT);
        end
      end
      chk("R10 no write strobe on read", (rd ? (wr_cnt - w0) : 0), 0);
      chk("R5 doe low in command phase", cmd_oe, 0);
      chk("R5/R6 doe only on matched read", oe_any, hit && rd);
      chk("R5 doe released after transfer", bus_doe, 0);
    end

    // R6: the missed write left index 3 untouched
    xfer(MY, 1'b1, 5'd3, 16'h0, 16, 1'b0, rv, oe_all, oe_any, cmd_oe);
    chk("R6 miss left register", rv, 16'hA5C3);

    // R8: bus clock toggles with select high are ignored
    w0 = wr_cnt; r0 = rd_cnt;
    bus_din = 1'b1;
    for (int k = 0; k < 12; k++) begin
      repeat (HALF) @(negedge clk); bus_clk = 1'b1;
      repeat (HALF) @(negedge clk); bus_clk = 1'b0;
    end
    chk("R8 no strobes while idle", (wr_cnt - w0) + (rd_cnt - r0), 0);
    chk("R8 doe low while idle", bus_doe, 0);
    xfer(MY, 1'b1, 5'd31, 16'h0, 16, 1'b0, rv, oe_all, oe_any, cmd_oe);
    chk("R8 count unaffected, read ok", rv, 16'h8001);

    // R7: abort a write after 10 value bits
    w0 = wr_cnt;
    xfer(MY, 1'b0, 5'd31, 16'h1234, 10, 1'b0, rv, oe_all, oe_any, cmd_oe);
    chk("R7 aborted write no strobe", wr_cnt - w0, 0);
    xfer(MY, 1'b1, 5'd31, 16'h0, 16, 1'b0, rv, oe_all, oe_any, cmd_oe);
    chk("R7 fresh command after abort", rv, 16'h8001);

    // R7: abort a read mid value phase releases the line
    xfer(MY, 1'b1, 5'd0, 16'h0, 5, 1'b1, rv, oe_all, oe_any, cmd_oe);
    chk("R7 doe on before abort", bus_doe, 1);
    bus_sel_n = 1'b1;
    repeat (HALF) @(negedge clk);
    chk("R7 doe off after abort", bus_doe, 0);

    // R9: back-to-back with select held low
    w0 = wr_cnt;
    xfer(MY, 1'b0, 5'd7, 16'h0F0F, 16, 1'b1, rv, oe_all, oe_any, cmd_oe);
    xfer(MY, 1'b1, 5'd7, 16'h0, 16, 1'b0, rv, oe_all, oe_any, cmd_oe);
    chk("R9 back-to-back write count", wr_cnt - w0, 1);
    chk("R9 back-to-back read value", rv, 16'h0F0F);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule